// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA transfer at a time, described by a byte address, a byte length and a read/write flag, and turns it into a run of memory requests that each stay inside one cache line. Only one of these line requests is outstanding at any moment. The next one is formed when the memory side acknowledges a write or returns data for a read. The first request starts at the transfer's own byte offset and stops at the end of its line. Every later request begins on a line boundary and covers a full line, or whatever remains of the transfer if that is less.

A local byte buffer sits beside the sequencer. Before a write transfer, the requester fills it through a simple byte write port. During a read transfer, returned line data is shifted into place and gathered into it. After completion, the requester reads the result through a combinational read port. While a transfer runs, new requests are refused rather than queued. Completion is reported with a one-cycle pulse, and the block is ready again in that same cycle.

Top module: `dma_line_splitter`

## Requirements
- R1: After reset, `busy`, `memValid` and `doneValid` are low and `reqReady` is high.
- R2: A request is taken on a cycle where `reqValid` is high and the block is idle. While busy, `reqReady` is low and `reqRefused` follows `reqValid`. The refused request changes nothing: the running transfer's chunk fields stay as they were.
- R3: The first chunk is presented in the cycle after acceptance. Its `memOffset` equals the low log2(LINE_BYTES) address bits, and its `memLen` is the request length when that fits in the line, otherwise LINE_BYTES minus the offset.
- R4: Each later chunk has `memOffset` 0, line address equal to start address plus bytes already issued, and length min(remaining, LINE_BYTES).
- R5: `memWrite` equals the request's write flag. `memLineAddr` is the chunk's byte address with its low log2(LINE_BYTES) bits cleared.
- R6: For a write chunk, byte lane `memOffset+k` (bits 8*lane upward) of `memWrData` carries buffer byte `pos+k`, where `pos` is the count of bytes in earlier chunks. `memByteEn` is set on exactly the lanes `memOffset` to `memOffset+memLen-1`.
- R7: For a read, lanes `memOffset` to `memOffset+memLen-1` of `rspData` are stored into buffer bytes `pos` onward, so that after completion buffer byte k holds the byte at address start+k.
- R8: Only one chunk is outstanding. After `memReady` takes a chunk, no new chunk appears until the matching response arrives (`ackValid` for writes, `rspValid` for reads). Responses that arrive with no chunk outstanding are ignored and leave the buffer unchanged.
- R9: While `memValid` is high and `memReady` is low, `memValid` and every chunk field hold steady.
- R10: The response to the final chunk makes `doneValid` pulse high for one cycle in the next cycle. In that cycle `busy` is already low and `reqReady` high.
- R11: A request of length 0 issues no chunk and pulses `doneValid` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqWrite | input | 1 | 1 = write (buffer to memory), 0 = read |
| reqAddr | input | ADDR_W | Transfer start byte address |
| reqLen | input | LEN_W | Transfer length in bytes, up to MAX_LEN |
| reqReady | output | 1 | Block idle, a request is taken this cycle |
| reqRefused | output | 1 | Request present while busy, refused |
| busy | output | 1 | Transfer in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| memValid | output | 1 | Chunk request valid |
| memReady | input | 1 | Memory side takes the chunk |
| memWrite | output | 1 | Chunk is a store (1) or load (0) |
| memLineAddr | output | ADDR_W | Line-aligned chunk address |
| memOffset | output | OFF_W | Byte offset of chunk inside line |
| memLen | output | LEN_W | Chunk length in bytes |
| memWrData | output | LINE_BYTES*8 | Store data placed in line lanes |
| memByteEn | output | LINE_BYTES | Lanes covered by the chunk |
| ackValid | input | 1 | Store acknowledge |
| rspValid | input | 1 | Load data return |
| rspData | input | LINE_BYTES*8 | Returned line data |
| bufWe | input | 1 | Buffer byte write strobe |
| bufWrIdx | input | IDX_W | Buffer write byte index |
| bufWrData | input | 8 | Buffer write byte |
| bufRdIdx | input | IDX_W | Buffer read byte index |
| bufRdData | output | 8 | Buffer byte at bufRdIdx |

## Verification
Several properties are checked in every cycle. A stalled chunk stays steady while it waits. No chunk ever extends past its line or exceeds the request. The issued byte count never passes the total. Completion never coincides with the busy flag, and a zero-length request finishes without a chunk. Other behaviour can only be shown by the bench's scenarios, which run unaligned, aligned and single-chunk transfers against a memory model. Those scenarios cover the exact chunk address and length sequence, the placement of store data in lanes, and the gathering of read data into the buffer. They also cover refusal of a second request and the ignoring of stray responses.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  // Strobes from the control FSM into the datapath, one cycle each.
  typedef struct packed {
    logic accept;    // latch a new transfer and form its first chunk
    logic formNext;  // form the following chunk after a response
    logic gather;    // store returned read data into the buffer
    logic retire;    // final response, mark all issued bytes complete
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

endpackage

// File: rtl/dma_split_ctrl.sv
module dma_split_ctrl
  import dma_split_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqLenZero,
  input  logic         memReady,
  input  logic         ackValid,
  input  logic         rspValid,
  input  logic         isWrite,
  input  logic         lastChunk,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         reqReady,
  output logic         reqRefused,
  output logic         memValid,
  output logic         doneValid
);

  seq_state_t state, stateNext;
  logic respIn;
  logic doneNext;

  // Only the response kind matching the transfer direction counts.
  assign respIn = isWrite ? ackValid : rspValid;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.accept = 1'b1;
          if (reqLenZero) doneNext = 1'b1;
          else            stateNext = ST_SEND;
        end
      end
      ST_SEND: begin
        if (memReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.gather = rspValid && !isWrite;
        if (respIn) begin
          if (lastChunk) begin
            strobe.retire = 1'b1;
            doneNext      = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobe.formNext = 1'b1;
            stateNext       = ST_SEND;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= doneNext;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign reqReady   = (state == ST_IDLE);
  assign reqRefused = reqValid && (state != ST_IDLE);
  assign memValid   = (state == ST_SEND);

  // R9: a presented chunk is not withdrawn before it is taken
  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid);

  // R10: completion pulse only once the block is free again
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy && reqReady);

  // R11: empty transfer finishes next cycle with no chunk
  assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqLenZero |=> doneValid && !memValid);

endmodule

// File: rtl/dma_split_dp.sv
module dma_split_dp
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int MAX_LEN    = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int IDX_W     = $clog2(MAX_LEN)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            strobe,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [LINE_BYTES*8-1:0] rspData,
  input  logic                    bufWe,
  input  logic [IDX_W-1:0]        bufWrIdx,
  input  logic [7:0]              bufWrData,
  input  logic [IDX_W-1:0]        bufRdIdx,
  output logic [7:0]              bufRdData,
  output logic                    isWrite,
  output logic                    lastChunk,
  output logic [ADDR_W-1:0]       chunkLine,
  output logic [OFF_W-1:0]        chunkOff,
  output logic [LEN_W-1:0]        chunkLen,
  output logic [LINE_BYTES*8-1:0] wrData,
  output logic [LINE_BYTES-1:0]   byteEn
);

  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
  localparam logic [LEN_W-1:0]  LINE_LEN  = LEN_W'(LINE_BYTES);

  logic [ADDR_W-1:0] startAddr;
  logic [LEN_W-1:0]  totalLen;
  logic [LEN_W-1:0]  issued;
  logic [LEN_W-1:0]  completed;
  logic [7:0]        bufMem [MAX_LEN];

  // Geometry of the chunk about to be formed
  logic [LEN_W-1:0]  reqOffLen, room, firstLen, remain, nextLen;
  logic [LEN_W-1:0]  srcBase, srcOff, srcLen, chunkOffLen;
  logic [ADDR_W-1:0] nextLine;
  logic              formAny;

  assign formAny     = strobe.accept || strobe.formNext;
  assign reqOffLen   = LEN_W'(reqAddr[OFF_W-1:0]);
  assign room        = LINE_LEN - reqOffLen;
  assign firstLen    = (reqLen <= room) ? reqLen : room;
  assign remain      = totalLen - issued;
  assign nextLen     = (remain < LINE_LEN) ? remain : LINE_LEN;
  assign srcBase     = strobe.accept ? '0 : issued;
  assign srcOff      = strobe.accept ? reqOffLen : '0;
  assign srcLen      = strobe.accept ? firstLen : nextLen;
  assign nextLine    = strobe.accept ? (reqAddr & LINE_MASK)
                                     : ((startAddr + ADDR_W'(issued)) & LINE_MASK);
  assign chunkOffLen = LEN_W'(chunkOff);
  assign lastChunk   = (issued == totalLen);

  // Per-lane steering: store data out of the buffer, load data into it
  logic [LINE_BYTES*8-1:0] laneData;
  logic [LINE_BYTES-1:0]   laneHit;
  logic [LINE_BYTES-1:0]   gatHit;
  logic [IDX_W-1:0]        gatIdx [LINE_BYTES];

  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lane
    localparam logic [LEN_W-1:0] LANE = LEN_W'(j);
    logic [IDX_W-1:0] srcIdx;
    assign laneHit[j] = (LANE >= srcOff) && (LANE < srcOff + srcLen);
    assign srcIdx     = IDX_W'(srcBase + LANE - srcOff);
    assign laneData[j*8 +: 8] = laneHit[j] ? bufMem[srcIdx] : 8'h00;
    assign gatHit[j]  = strobe.gather && (LANE >= chunkOffLen) &&
                        (LANE < chunkOffLen + chunkLen);
    assign gatIdx[j]  = IDX_W'(completed + LANE - chunkOffLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      totalLen  <= '0;
      issued    <= '0;
      completed <= '0;
      isWrite   <= 1'b0;
      chunkLine <= '0;
      chunkOff  <= '0;
      chunkLen  <= '0;
      wrData    <= '0;
      byteEn    <= '0;
    end else begin
      if (strobe.accept) begin
        startAddr <= reqAddr;
        totalLen  <= reqLen;
        isWrite   <= reqWrite;
        completed <= '0;
      end
      if (strobe.formNext || strobe.retire) completed <= issued;
      if (formAny) begin
        chunkLine <= nextLine;
        chunkOff  <= srcOff[OFF_W-1:0];
        chunkLen  <= srcLen;
        issued    <= srcBase + srcLen;
        wrData    <= laneData;
        byteEn    <= laneHit;
      end
    end
  end

  // Byte buffer: requester port first, gathered read data takes priority
  always_ff @(posedge clk) begin
    if (bufWe) bufMem[bufWrIdx] <= bufWrData;
    for (int j = 0; j < LINE_BYTES; j++) begin
      if (gatHit[j]) bufMem[gatIdx[j]] <= rspData[j*8 +: 8];
    end
  end

  assign bufRdData = bufMem[bufRdIdx];

  // R4: the issue pointer never runs past the transfer length
  assert_issued_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    issued <= totalLen && completed <= issued);

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int MAX_LEN    = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int IDX_W     = $clog2(MAX_LEN)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LEN_W-1:0]        reqLen,
  output logic                    reqReady,
  output logic                    reqRefused,
  output logic                    busy,
  output logic                    doneValid,
  output logic                    memValid,
  input  logic                    memReady,
  output logic                    memWrite,
  output logic [ADDR_W-1:0]       memLineAddr,
  output logic [OFF_W-1:0]        memOffset,
  output logic [LEN_W-1:0]        memLen,
  output logic [LINE_BYTES*8-1:0] memWrData,
  output logic [LINE_BYTES-1:0]   memByteEn,
  input  logic                    ackValid,
  input  logic                    rspValid,
  input  logic [LINE_BYTES*8-1:0] rspData,
  input  logic                    bufWe,
  input  logic [IDX_W-1:0]        bufWrIdx,
  input  logic [7:0]              bufWrData,
  input  logic [IDX_W-1:0]        bufRdIdx,
  output logic [7:0]              bufRdData
);

  ctrl_strobe_t strobe;
  logic         lastChunk;

  dma_split_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLenZero (reqLen == '0),
    .memReady   (memReady),
    .ackValid   (ackValid),
    .rspValid   (rspValid),
    .isWrite    (memWrite),
    .lastChunk  (lastChunk),
    .strobe     (strobe),
    .busy       (busy),
    .reqReady   (reqReady),
    .reqRefused (reqRefused),
    .memValid   (memValid),
    .doneValid  (doneValid)
  );

  dma_split_dp #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_LEN    (MAX_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .rspData   (rspData),
    .bufWe     (bufWe),
    .bufWrIdx  (bufWrIdx),
    .bufWrData (bufWrData),
    .bufRdIdx  (bufRdIdx),
    .bufRdData (bufRdData),
    .isWrite   (memWrite),
    .lastChunk (lastChunk),
    .chunkLine (memLineAddr),
    .chunkOff  (memOffset),
    .chunkLen  (memLen),
    .wrData    (memWrData),
    .byteEn    (memByteEn)
  );

  // R9: chunk contents frozen while the memory side stalls
  assert_stable_chunk_R9: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=>
      $stable(memLineAddr) && $stable(memOffset) && $stable(memLen) &&
      $stable(memWrData) && $stable(memByteEn) && $stable(memWrite));

  // R3: a presented chunk is non-empty and never crosses its line
  assert_chunk_in_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memLen != '0) &&
                 (LEN_W'(memOffset) + memLen <= LEN_W'(LINE_BYTES)));

endmodule

// File: tb/dma_line_splitter_tb.sv
`timescale 1ns/1ps
module dma_line_splitter_tb;

  localparam int ADDR_W = 32;
  localparam int LINE   = 16;
  localparam int MAXL   = 64;
  localparam int OFF_W  = $clog2(LINE);
  localparam int LEN_W  = $clog2(MAXL + 1);
  localparam int IDX_W  = $clog2(MAXL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic reqReady, reqRefused, busy, doneValid, memValid, memWrite;
  logic memReady = 1'b0;
  logic [ADDR_W-1:0] memLineAddr;
  logic [OFF_W-1:0]  memOffset;
  logic [LEN_W-1:0]  memLen;
  logic [LINE*8-1:0] memWrData;
  logic [LINE-1:0]   memByteEn;
  logic ackValid = 1'b0, rspValid = 1'b0;
  logic [LINE*8-1:0] rspData = '0;
  logic bufWe = 1'b0;
  logic [IDX_W-1:0] bufWrIdx = '0, bufRdIdx = '0;
  logic [7:0] bufWrData = '0, bufRdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_line_splitter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqReady(reqReady),
    .reqRefused(reqRefused), .busy(busy), .doneValid(doneValid),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memLineAddr(memLineAddr), .memOffset(memOffset), .memLen(memLen),
    .memWrData(memWrData), .memByteEn(memByteEn), .ackValid(ackValid),
    .rspValid(rspValid), .rspData(rspData), .bufWe(bufWe),
    .bufWrIdx(bufWrIdx), .bufWrData(bufWrData), .bufRdIdx(bufRdIdx),
    .bufRdData(bufRdData)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wrPat(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] memByte(input int a);
    return 8'(a & 255) ^ 8'hA5;
  endfunction

  task automatic loadBuf(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bufWe = 1'b1; bufWrIdx = IDX_W'(k); bufWrData = wrPat(k);
    end
    @(negedge clk);
    bufWe = 1'b0;
  endtask

  task automatic readBuf(input int k, output logic [7:0] v);
    bufRdIdx = IDX_W'(k);
    #1 v = bufRdData;
  endtask

  task automatic checkChunk(input bit wr, input int addr, input int pos, input int off,
                            input int clen, input string tag);
    int lineA;
    lineA = (addr + pos) & ~(LINE - 1);
    chk(memValid === 1'b1, {tag, " memValid"}, memValid, 1);
    chk(memLineAddr == ADDR_W'(lineA), "R5 line address", memLineAddr, lineA);
    chk(memWrite == wr, "R5 memWrite", memWrite, wr);
    chk(memOffset == OFF_W'(off), {tag, " offset"}, memOffset, off);
    chk(memLen == LEN_W'(clen), {tag, " length"}, memLen, clen);
    if (wr) begin
      for (int j = 0; j < LINE; j++) begin
        bit in = (j >= off) && (j < off + clen);
        chk(memByteEn[j] == in, "R6 byte enable", memByteEn[j], in);
        if (in)
          chk(memWrData[j*8 +: 8] == wrPat(pos + j - off), "R6 lane data",
              memWrData[j*8 +: 8], wrPat(pos + j - off));
      end
    end
  endtask

  // Generic transfer with a memory model; optional stall and intrusion.
  task automatic runXfer(input bit wr, input int addr, input int len,
                         input bit stall, input bit poke);
    int pos, off, clen, lineA;
    logic [ADDR_W-1:0] heldLine;
    logic [7:0] v;
    @(negedge clk);
    chk(reqReady === 1'b1, "R2 ready when idle", reqReady, 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    pos = 0;
    while (pos < len) begin
      off  = (pos == 0) ? (addr % LINE) : 0;
      clen = (len - pos < LINE - off) ? (len - pos) : (LINE - off);
      lineA = (addr + pos) & ~(LINE - 1);
      checkChunk(wr, addr, pos, off, clen, (pos == 0) ? "R3" : "R4");
      if (poke && pos == 0) begin
        heldLine = memLineAddr;
        reqValid = 1'b1; reqWrite = ~wr; reqAddr = 32'h0000_0F00; reqLen = 7'd5;
        rspValid = 1'b1; ackValid = 1'b1; rspData = '1;
        #1;
        chk(reqRefused === 1'b1, "R2 refused while busy", reqRefused, 1);
        chk(reqReady === 1'b0, "R2 not ready while busy", reqReady, 0);
        @(negedge clk);
        reqValid = 1'b0; rspValid = 1'b0; ackValid = 1'b0;
        chk(memValid === 1'b1, "R8 stray response before handshake", memValid, 1);
        chk(memLineAddr == heldLine, "R2 refused request ignored", memLineAddr, heldLine);
        checkChunk(wr, addr, pos, off, clen, "R2");
      end
      if (stall) begin
        repeat (2) @(negedge clk);
        checkChunk(wr, addr, pos, off, clen, "R9");
      end
      memReady = 1'b1;
      @(negedge clk);
      memReady = 1'b0;
      chk(memValid === 1'b0, "R8 chunk taken", memValid, 0);
      @(negedge clk);
      chk(memValid === 1'b0, "R8 waits for response", memValid, 0);
      if (wr) ackValid = 1'b1;
      else begin
        rspValid = 1'b1;
        for (int j = 0; j < LINE; j++) rspData[j*8 +: 8] = memByte(lineA + j);
      end
      @(negedge clk);
      ackValid = 1'b0; rspValid = 1'b0; rspData = '0;
      pos += clen;
    end
    chk(doneValid === 1'b1, "R10 done pulse", doneValid, 1);
    chk(busy === 1'b0, "R10 idle with done", busy, 0);
    chk(reqReady === 1'b1, "R10 ready with done", reqReady, 1);
    @(negedge clk);
    chk(doneValid === 1'b0, "R10 single pulse", doneValid, 0);
    chk(memValid === 1'b0, "R10 no chunk after done", memValid, 0);
    if (!wr) begin
      for (int k = 0; k < len; k++) begin
        readBuf(k, v);
        chk(v == memByte(addr + k), "R7 gathered byte", v, memByte(addr + k));
      end
    end
  endtask

  task automatic testReset();
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(memValid === 1'b0, "R1 memValid", memValid, 0);
    chk(doneValid === 1'b0, "R1 doneValid", doneValid, 0);
    chk(reqReady === 1'b1, "R1 reqReady", reqReady, 1);
  endtask

  task automatic testUnalignedWrite();
    loadBuf(40);
    runXfer(1'b1, 32'h105, 40, 1'b1, 1'b1);
  endtask

  task automatic testShortRead();
    runXfer(1'b0, 32'h203, 9, 1'b0, 1'b0);
  endtask

  task automatic testLongRead();
    runXfer(1'b0, 32'h30C, 37, 1'b1, 1'b1);
  endtask

  task automatic testAlignedWrite();
    loadBuf(32);
    runXfer(1'b1, 32'h400, 32, 1'b0, 1'b0);
  endtask

  task automatic testStrayIdle();
    logic [7:0] v;
    @(negedge clk);
    rspValid = 1'b1; ackValid = 1'b1; rspData = '0;
    @(negedge clk);
    rspValid = 1'b0; ackValid = 1'b0;
    chk(memValid === 1'b0, "R8 idle response no chunk", memValid, 0);
    chk(doneValid === 1'b0, "R8 idle response no done", doneValid, 0);
    readBuf(0, v);
    chk(v == memByte(32'h203), "R8 idle response buffer kept", v, memByte(32'h203));
  endtask

  task automatic testZeroLen();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 32'h777; reqLen = '0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(doneValid === 1'b1, "R11 done next cycle", doneValid, 1);
    chk(memValid === 1'b0, "R11 no chunk", memValid, 0);
    chk(busy === 1'b0, "R11 not busy", busy, 0);
    @(negedge clk);
    chk(memValid === 1'b0, "R11 still no chunk", memValid, 0);
    chk(doneValid === 1'b0, "R11 pulse ends", doneValid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnalignedWrite();
    testShortRead();
    testStrayIdle();
    testLongRead();
    testAlignedWrite();
    testZeroLen();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule